// File: doc/BRIEF.md
# Serial Configuration Loader for a Two-Channel Synthesizer

This block takes configuration words from a three-wire serial port (data, shift clock, load strobe) and places each word in one of two per-channel holding registers. One register feeds the transmit synthesizer and the other feeds the receive synthesizer. A single shared shift register collects each word. When the load strobe rises, the most recently shifted bit chooses which channel register is written.

Each channel register holds three things: a swallow count, a main counter value and two mode bits for that channel's divider and phase detector. Two further bits in the word are common settings: the reference ratio select and the monitor output select. These are held beside the channel registers.

Each channel has a supply-good input. While a channel is unpowered, its register and valid flag are held clear. The receive supply also powers the common domain, so losing it clears the common settings as well.

The serial inputs are level signals that have already been synchronized to the system clock. Edges are found by comparing each input with its value one clock earlier.

Each channel has an analog-switch enable output. It is high while the load strobe is high, and at all other times the switch is taken to be open (high impedance).

Top module: `slcfg_top`

## Requirements
- R1: After reset, every channel field, both valid flags and both common settings are zero, and both switch enables are low.
- R2: Each rising edge of `serClk` seen while `loadEn` is low shifts `serData` into the 23-bit shift register. The earliest of the last 23 bits lands in word bit 0 and the latest in word bit 22.
- R3: On a load, word bit 22 picks the destination: 1 writes the transmit register and 0 writes the receive register. The other channel register keeps its value.
- R4: Word field positions are fixed. Bits 6:0 are the swallow count, bits 17:7 the main count, bit 18 mode bit 0 (prescaler modulus, 1 = larger) and bit 19 mode bit 1 (phase polarity invert). Bit 20 is the reference ratio select and bit 21 the monitor select.
- R5: A register update happens only on a rising edge of `loadEn`. The result appears on the outputs one system clock later. Shift clock edges that arrive while `loadEn` is high leave the shift register unchanged.
- R6: While `pwrTx` is low, the transmit fields and `txValid` read zero. The receive fields and the common settings are untouched.
- R7: While `pwrRx` is low, the receive fields, `rxValid`, `refSel` and `monSel` read zero. The transmit fields are untouched.
- R8: A channel's valid flag goes high on the first load into that channel after reset or after power is restored.
- R9: `txSwEn` and `rxSwEn` are high exactly while `loadEn` is high.
- R10: A load aimed at an unpowered channel has no effect. That channel stays zero and invalid after power returns, until it is loaded again.
- R11: When more than 23 bits are shifted before a load, only the last 23 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock (synchronized level) |
| serData | input | 1 | Serial data bit |
| loadEn | input | 1 | Load strobe; its rising edge writes a register |
| pwrTx | input | 1 | Transmit channel supply good |
| pwrRx | input | 1 | Receive/common domain supply good |
| txSwallow | output | SWALLOW_W | Transmit swallow count |
| txMain | output | MAIN_W | Transmit main count |
| txMode | output | MODE_W | Transmit mode bits |
| txValid | output | 1 | Transmit register loaded |
| rxSwallow | output | SWALLOW_W | Receive swallow count |
| rxMain | output | MAIN_W | Receive main count |
| rxMode | output | MODE_W | Receive mode bits |
| rxValid | output | 1 | Receive register loaded |
| refSel | output | 1 | Reference ratio select |
| monSel | output | 1 | Monitor output select |
| txSwEn | output | 1 | Transmit analog switch enable |
| rxSwEn | output | 1 | Receive analog switch enable |

## Verification
The bench uses the default widths: 7-bit swallow, 11-bit main and 2 mode bits, which make a 23-bit word. With these widths the all-ones counts (127 and 2047) can be driven and read back to confirm that no field bleeds into its neighbour. The walking patterns used on the mode and common bits expose any off-by-one in the field positions. Words longer than 23 bits, shift clocks sent while the strobe is held high, and power drops on each side show that the shared shifter and the clear logic keep the two channels apart.

// File: rtl/slcfg_pkg.sv
package slcfg_pkg;

  // Strobes from control to datapath, one clock wide except the power levels.
  typedef struct packed {
    logic shiftEn;  // take one serial bit
    logic loadTx;   // copy payload into transmit register
    logic loadRx;   // copy payload into receive register
    logic loadCom;  // copy common settings
    logic keepTx;   // transmit domain powered
    logic keepRx;   // receive/common domain powered
  } strobe_t;

  localparam int COMMON_W = 2;

endpackage

// File: rtl/slcfg_ctrl.sv
module slcfg_ctrl
  import slcfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    loadEn,
  input  logic    pwrTx,
  input  logic    pwrRx,
  input  logic    destBit,
  output strobe_t stb
);

  logic serClkQ;
  logic loadEnQ;
  logic loadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ <= 1'b0;
      loadEnQ <= 1'b0;
    end else begin
      serClkQ <= serClk;
      loadEnQ <= loadEn;
    end
  end

  assign loadRise = loadEn & ~loadEnQ;

  always_comb begin
    stb         = '0;
    stb.shiftEn = serClk & ~serClkQ & ~loadEn;
    stb.loadTx  = loadRise & destBit & pwrTx;
    stb.loadRx  = loadRise & ~destBit & pwrRx;
    stb.loadCom = loadRise & pwrRx;
    stb.keepTx  = pwrTx;
    stb.keepRx  = pwrRx;
  end

  // R3: a load never targets both channels
  p_one_dest_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadTx, stb.loadRx}));

  // R5: a strobe held high produces no second load
  p_single_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> !(stb.loadTx || stb.loadRx || stb.loadCom));

endmodule

// File: rtl/slcfg_chan.sv
module slcfg_chan #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powered,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             valid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (!powered) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (load) begin
      q     <= din;
      valid <= 1'b1;
    end
  end

  // R6/R7: an unpowered channel reads clear on the next cycle
  p_clear_on_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    !powered |=> (q == '0) && !valid);

  // R8: a load into a powered channel marks it valid
  p_valid_after_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (powered && load) |=> valid);

  // R3: without a load the register holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (powered && !load) |=> $stable(q));

endmodule

// File: rtl/slcfg_dp.sv
module slcfg_dp
  import slcfg_pkg::*;
#(
  parameter int SWALLOW_W = 7,
  parameter int MAIN_W    = 11,
  parameter int MODE_W    = 2
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    serData,
  input  strobe_t                                 stb,
  output logic                                    destBit,
  output logic [SWALLOW_W+MAIN_W+MODE_W+COMMON_W:0] srWord,
  output logic [SWALLOW_W+MAIN_W+MODE_W-1:0]      txWord,
  output logic [SWALLOW_W+MAIN_W+MODE_W-1:0]      rxWord,
  output logic                                    txValid,
  output logic                                    rxValid,
  output logic [COMMON_W-1:0]                     comWord
);

  localparam int PAY_W = SWALLOW_W + MAIN_W + MODE_W;
  localparam int SR_W  = PAY_W + COMMON_W + 1;

  logic [SR_W-1:0]  sr;
  logic [PAY_W-1:0] chanQ    [2];
  logic             chanV    [2];
  logic             chanLoad [2];
  logic             chanPwr  [2];

  // Newest bit enters at the top; the earliest ends at bit 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sr <= '0;
    else if (stb.shiftEn) sr <= {serData, sr[SR_W-1:1]};
  end

  assign destBit = sr[SR_W-1];
  assign srWord  = sr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            comWord <= '0;
    else if (!stb.keepRx) comWord <= '0;
    else if (stb.loadCom) comWord <= sr[PAY_W +: COMMON_W];
  end

  assign chanLoad[0] = stb.loadTx;
  assign chanLoad[1] = stb.loadRx;
  assign chanPwr[0]  = stb.keepTx;
  assign chanPwr[1]  = stb.keepRx;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    slcfg_chan #(.WIDTH(PAY_W)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .powered (chanPwr[ch]),
      .load    (chanLoad[ch]),
      .din     (sr[PAY_W-1:0]),
      .q       (chanQ[ch]),
      .valid   (chanV[ch])
    );
  end

  assign txWord  = chanQ[0];
  assign rxWord  = chanQ[1];
  assign txValid = chanV[0];
  assign rxValid = chanV[1];

  // R7: common settings are clear whenever the receive domain was down
  p_common_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.keepRx |=> (comWord == '0));

endmodule

// File: rtl/slcfg_top.sv
module slcfg_top
  import slcfg_pkg::*;
#(
  parameter int SWALLOW_W = 7,
  parameter int MAIN_W    = 11,
  parameter int MODE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 loadEn,
  input  logic                 pwrTx,
  input  logic                 pwrRx,
  output logic [SWALLOW_W-1:0] txSwallow,
  output logic [MAIN_W-1:0]    txMain,
  output logic [MODE_W-1:0]    txMode,
  output logic                 txValid,
  output logic [SWALLOW_W-1:0] rxSwallow,
  output logic [MAIN_W-1:0]    rxMain,
  output logic [MODE_W-1:0]    rxMode,
  output logic                 rxValid,
  output logic                 refSel,
  output logic                 monSel,
  output logic                 txSwEn,
  output logic                 rxSwEn
);

  localparam int PAY_W = SWALLOW_W + MAIN_W + MODE_W;
  localparam int SR_W  = PAY_W + COMMON_W + 1;

  strobe_t           stb;
  logic              destBit;
  logic [SR_W-1:0]   srWord;
  logic [PAY_W-1:0]  txWord;
  logic [PAY_W-1:0]  rxWord;
  logic [COMMON_W-1:0] comWord;

  slcfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .loadEn  (loadEn),
    .pwrTx   (pwrTx),
    .pwrRx   (pwrRx),
    .destBit (destBit),
    .stb     (stb)
  );

  slcfg_dp #(
    .SWALLOW_W (SWALLOW_W),
    .MAIN_W    (MAIN_W),
    .MODE_W    (MODE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .serData (serData),
    .stb     (stb),
    .destBit (destBit),
    .srWord  (srWord),
    .txWord  (txWord),
    .rxWord  (rxWord),
    .txValid (txValid),
    .rxValid (rxValid),
    .comWord (comWord)
  );

  assign txSwallow = txWord[SWALLOW_W-1:0];
  assign txMain    = txWord[SWALLOW_W +: MAIN_W];
  assign txMode    = txWord[SWALLOW_W+MAIN_W +: MODE_W];
  assign rxSwallow = rxWord[SWALLOW_W-1:0];
  assign rxMain    = rxWord[SWALLOW_W +: MAIN_W];
  assign rxMode    = rxWord[SWALLOW_W+MAIN_W +: MODE_W];
  assign refSel    = comWord[0];
  assign monSel    = comWord[1];
  assign txSwEn    = loadEn;
  assign rxSwEn    = loadEn;

  // R5: the shifter is frozen while the load strobe is high
  p_freeze_on_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> $stable(srWord));

  // R2: a shift moves the previous word down by one place
  p_shift_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |=> (srWord[SR_W-2:0] == $past(srWord[SR_W-1:1])));

endmodule

// File: tb/sim_slcfg_top.sv
module sim_slcfg_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0, serData = 1'b0, loadEn = 1'b0;
  logic        pwrTx = 1'b1, pwrRx = 1'b1;
  logic [6:0]  txSwallow, rxSwallow;
  logic [10:0] txMain, rxMain;
  logic [1:0]  txMode, rxMode;
  logic        txValid, rxValid, refSel, monSel, txSwEn, rxSwEn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  slcfg_top u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .loadEn(loadEn),
    .pwrTx(pwrTx), .pwrRx(pwrRx),
    .txSwallow(txSwallow), .txMain(txMain), .txMode(txMode), .txValid(txValid),
    .rxSwallow(rxSwallow), .rxMain(rxMain), .rxMode(rxMode), .rxValid(rxValid),
    .refSel(refSel), .monSel(monSel), .txSwEn(txSwEn), .rxSwEn(rxSwEn)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [22:0] mk(int sw, int mn, int md, bit rs, bit ms, bit dst);
    logic [22:0] w;
    w = {dst, ms, rs, md[1:0], mn[10:0], sw[6:0]};
    return w;
  endfunction

  task automatic sendBits(logic [31:0] w, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); serData = w[i]; serClk = 1'b1;
      @(negedge clk); serClk = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic pulseLoad(string req);
    @(negedge clk); loadEn = 1'b1;
    @(negedge clk);
    chk(req, "txSwEn high", int'(txSwEn), 1);
    chk(req, "rxSwEn high", int'(rxSwEn), 1);
    loadEn = 1'b0;
    @(negedge clk);
    chk(req, "txSwEn low", int'(txSwEn), 0);
  endtask

  task automatic expTx(string req, int sw, int mn, int md, int v);
    chk(req, "txSwallow", int'(txSwallow), sw);
    chk(req, "txMain", int'(txMain), mn);
    chk(req, "txMode", int'(txMode), md);
    chk(req, "txValid", int'(txValid), v);
  endtask

  task automatic expRx(string req, int sw, int mn, int md, int v);
    chk(req, "rxSwallow", int'(rxSwallow), sw);
    chk(req, "rxMain", int'(rxMain), mn);
    chk(req, "rxMode", int'(rxMode), md);
    chk(req, "rxValid", int'(rxValid), v);
  endtask

  task automatic expCom(string req, int rs, int ms);
    chk(req, "refSel", int'(refSel), rs);
    chk(req, "monSel", int'(monSel), ms);
  endtask

  // R1
  task automatic tResetState();
    expTx("R1", 0, 0, 0, 0);
    expRx("R1", 0, 0, 0, 0);
    expCom("R1", 0, 0);
    chk("R1", "txSwEn", int'(txSwEn), 0);
    chk("R1", "rxSwEn", int'(rxSwEn), 0);
  endtask

  // R2 R3 R4 R8 R9: load the transmit register
  task automatic tLoadTx();
    sendBits(32'(mk(7'h55, 11'h5A3, 2, 1, 0, 1)), 23);
    pulseLoad("R9");
    expTx("R4", 'h55, 'h5A3, 2, 1);
    expRx("R3", 0, 0, 0, 0);
    expCom("R4", 1, 0);
  endtask

  // R3 R4: all-ones counts into the receive register
  task automatic tLoadRx();
    sendBits(32'(mk(127, 2047, 1, 0, 1, 0)), 23);
    pulseLoad("R9");
    expRx("R4", 127, 2047, 1, 1);
    expTx("R3", 'h55, 'h5A3, 2, 1);
    expCom("R4", 0, 1);
  endtask

  // R11: extra leading bits fall off the end
  task automatic tLongWord();
    logic [31:0] w;
    w = {mk(7'h0F, 11'h123, 3, 1, 1, 0), 5'b10101};
    sendBits(w, 28);
    pulseLoad("R11");
    expRx("R11", 'h0F, 'h123, 3, 1);
    expCom("R11", 1, 1);
  endtask

  // R5: shifts while the strobe is high are dropped; a new rise reloads
  task automatic tShiftDuringLoad();
    logic [22:0] w;
    w = mk(7'h01, 11'h002, 0, 0, 0, 1);
    @(negedge clk); loadEn = 1'b1;
    for (int i = 0; i < 23; i++) begin
      @(negedge clk); serData = w[i]; serClk = 1'b1;
      @(negedge clk); serClk = 1'b0;
    end
    @(negedge clk); loadEn = 1'b0;
    @(negedge clk);
    expTx("R5", 'h55, 'h5A3, 2, 1);
    pulseLoad("R5");
    expRx("R5", 'h0F, 'h123, 3, 1);
    expTx("R5", 'h55, 'h5A3, 2, 1);
  endtask

  // R6 R10 R8
  task automatic tTxPowerDown();
    @(negedge clk); pwrTx = 1'b0;
    @(negedge clk);
    expTx("R6", 0, 0, 0, 0);
    expRx("R6", 'h0F, 'h123, 3, 1);
    expCom("R6", 1, 1);
    sendBits(32'(mk(7'h33, 11'h444, 1, 1, 1, 1)), 23);
    pulseLoad("R10");
    @(negedge clk); pwrTx = 1'b1;
    @(negedge clk);
    expTx("R10", 0, 0, 0, 0);
    pulseLoad("R8");
    expTx("R8", 'h33, 'h444, 1, 1);
  endtask

  // R7
  task automatic tRxPowerDown();
    @(negedge clk); pwrRx = 1'b0;
    @(negedge clk);
    expRx("R7", 0, 0, 0, 0);
    expCom("R7", 0, 0);
    expTx("R7", 'h33, 'h444, 1, 1);
    @(negedge clk); pwrRx = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tLoadTx();
    tLoadRx();
    tLongWord();
    tShiftDuringLoad();
    tTxPowerDown();
    tRxPowerDown();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule